// File: doc/BRIEF.md
# Processor System Register Bank

A bank of 16-bit processor control and status registers behind a simple word/byte bus. Each request carries a 5-bit byte address. Bits 4:1 pick one of sixteen word slots, and bit 0 only picks the byte lane. The bank holds eight registers:

- a memory error register that hardware sets and software clears one bit at a time
- a cache control register
- a maintenance register
- a hit/miss register
- a CPU error register whose stack and bus flags are adjusted each time it is read
- a microbreak register
- a fixed system identifier
- a read-only memory size value derived from a parameter

The block accepts a request in every cycle in which `req_valid` is high and has no back-pressure. Every request, whether a read or a write, produces exactly one response pulse one cycle later. A slot with no register behind it answers with `rsp_nxm` instead of data. Error sources elsewhere in the chip report through single-cycle event inputs. The bus fabric, the cache and the memory controller sit outside this block.

Top module: `sysreg_bank`

## Requirements
- R1: The slot number is `req_addr[4:1]`. `req_addr[0]` selects only the byte lane, so a word read at an odd address returns the same slot as the even address. The slots that hold a register are: 2 memory error, 3 cache control, 4 maintenance, 5 hit/miss, 8 memory size, 10 system ID, 11 CPU error, 13 microbreak.
- R2: A request to any other slot returns `rsp_nxm`=1 with `rsp_rdata`=0, and a write to such a slot changes no register.
- R3: A byte access (`req_byte`=1) expects its data in its own lane of `req_wdata`. At an odd address a byte write replaces bits 15:8 and keeps bits 7:0. At an even address it replaces bits 7:0 and keeps bits 15:8.
- R4: Each request cycle produces `rsp_valid`=1 in the next cycle only. A write answers with `rsp_rdata`=0.
- R5: Each register applies a write mask and a read mask. Bits outside the write mask keep their value, and bits outside the read mask read as 0. The default masks are (read/write): cache control 0x3FFF/0x3FFF, maintenance 0xFFFF/0x00FF, microbreak 0x00FF/0x00FF, memory error 0xFFFF/0xFFFF.
- R6: Writing the memory error register clears each written 1 bit and keeps the others. Bit n of `mem_err_evt` sets bit n, and a set in the same cycle as a clear wins.
- R7: CPU error bits are: 0 bus summary, 2 stack red, 3 stack yellow, 4 timeout, 5 non-existent memory, 6 odd address. The read mask is 0x007D. Reading the register while bit 3 is set clears bit 3 and sets bit 2, and the returned data already shows that change.
- R8: Reading the CPU error register while any of bits 4, 5 or 6 is set also sets bit 0, and the returned data shows it.
- R9: Any word or byte write to the CPU error register clears all of it. The event inputs `ev_odd`, `ev_nxm`, `ev_tmo`, `ev_yel` and `ev_red` set bits 6, 5, 4, 3 and 2, and an event wins over a clear or read update in the same cycle.
- R10: The memory size slot reads (MEM_BYTES >> 6) - 1, which is 4095 for the default of 262144, and writes to it are ignored.
- R11: The system ID reads 0x1234 after reset and is read-only.
- R12: The hit/miss register has write mask 0x00FF and read mask 0xFFFF, and it always reads with bit 3 forced to 1.
- R13: A synchronous reset (`rst`=1) clears every register and the response outputs. The system ID is the only exception and returns to 0x1234.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_byte | input | 1 | 1 byte access, 0 word access |
| req_addr | input | 5 | Byte address; bits 4:1 slot, bit 0 lane |
| req_wdata | input | 16 | Write data, byte data in its own lane |
| mem_err_evt | input | 16 | Per-bit set pulses for the memory error register |
| ev_odd | input | 1 | Odd-address error pulse |
| ev_nxm | input | 1 | Non-existent-memory error pulse |
| ev_tmo | input | 1 | Bus timeout error pulse |
| ev_yel | input | 1 | Stack yellow-zone pulse |
| ev_red | input | 1 | Stack red-zone pulse |
| rsp_valid | output | 1 | Response present |
| rsp_nxm | output | 1 | Addressed slot is empty |
| rsp_rdata | output | 16 | Read data |

## Verification
Read data, `rsp_nxm` and `rsp_valid` are due in the cycle after the request edge. A register change caused by a write, a read side effect or an event becomes visible to any request issued from the following edge on. The bench's reference model updates its expected response and its register copy at the same edge as the design. Comparisons are made at the falling edge, when both are settled. Tests that pair an event with a write or read in one cycle therefore check who wins on the very next read.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int DW = 16;
  localparam int AW = 5;
  localparam int NSLOT = 1 << (AW - 1);

  typedef enum logic [3:0] {
    SLOT_MEMERR  = 4'd2,
    SLOT_CACHE   = 4'd3,
    SLOT_MAINT   = 4'd4,
    SLOT_HITMISS = 4'd5,
    SLOT_SIZE    = 4'd8,
    SLOT_SYSID   = 4'd10,
    SLOT_CPUERR  = 4'd11,
    SLOT_UBRK    = 4'd13
  } slot_e;

  localparam logic [NSLOT-1:0] IMPL_SLOTS = 16'h2D3C;

  localparam int CE_SUM = 0;
  localparam int CE_RED = 2;
  localparam int CE_YEL = 3;
  localparam int CE_TMO = 4;
  localparam int CE_NXM = 5;
  localparam int CE_ODD = 6;

  localparam int HM_FORCE_BIT = 3;

  function automatic logic [DW-1:0] lane_mask(input logic is_byte, input logic odd);
    if (!is_byte) return '1;
    return odd ? {{(DW/2){1'b1}}, {(DW/2){1'b0}}} : {{(DW/2){1'b0}}, {(DW/2){1'b1}}};
  endfunction
endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
#(
  parameter logic [NSLOT-1:0] IMPL = IMPL_SLOTS
) (
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  output logic [NSLOT-1:0] hit,
  output logic             nxm
);
  logic [AW-2:0] slot;
  assign slot = req_addr[AW-1:1];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (IMPL[i]) begin : g_impl
      assign hit[i] = req_valid && (slot == i[AW-2:0]);
    end else begin : g_empty
      assign hit[i] = 1'b0;
    end
  end

  assign nxm = req_valid && !(|hit);
endmodule

// File: rtl/sysreg_cell.sv
module sysreg_cell #(
  parameter int            W       = 16,
  parameter logic [W-1:0]  RST_VAL = '0,
  parameter logic [W-1:0]  WMASK   = '1,
  parameter bit            W1C     = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] lane_m,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set_evt,
  output logic [W-1:0] q
);
  logic [W-1:0] eff;
  logic [W-1:0] upd;

  assign eff = lane_m & WMASK;

  if (W1C) begin : g_w1c
    assign upd = q & ~(wdata & eff);
  end else begin : g_merge
    assign upd = (q & ~eff) | (wdata & eff);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= (wr_en ? upd : q) | set_evt;
  end
endmodule

// File: rtl/sysreg_cpuerr.sv
module sysreg_cpuerr
  import sysreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] evt,
  output logic [DW-1:0] q,
  output logic [DW-1:0] rd_view
);
  always_comb begin
    rd_view = q;
    if (rd_view[CE_YEL]) begin
      rd_view[CE_YEL] = 1'b0;
      rd_view[CE_RED] = 1'b1;
    end
    if (rd_view[CE_TMO] || rd_view[CE_NXM] || rd_view[CE_ODD])
      rd_view[CE_SUM] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= evt;
    else if (rd_en) q <= rd_view | evt;
    else            q <= q | evt;
  end
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
#(
  parameter int unsigned MEM_BYTES   = 262144,
  parameter logic [15:0] SYSID_RST   = 16'h1234,
  parameter logic [15:0] MEM_RMASK   = 16'hFFFF,
  parameter logic [15:0] MEM_WMASK   = 16'hFFFF,
  parameter logic [15:0] CCR_RMASK   = 16'h3FFF,
  parameter logic [15:0] CCR_WMASK   = 16'h3FFF,
  parameter logic [15:0] MAINT_RMASK = 16'hFFFF,
  parameter logic [15:0] MAINT_WMASK = 16'h00FF,
  parameter logic [15:0] HM_RMASK    = 16'hFFFF,
  parameter logic [15:0] HM_WMASK    = 16'h00FF,
  parameter logic [15:0] UBRK_RMASK  = 16'h00FF,
  parameter logic [15:0] UBRK_WMASK  = 16'h00FF,
  parameter logic [15:0] CE_RMASK    = 16'h007D
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_byte,
  input  logic [4:0]  req_addr,
  input  logic [15:0] req_wdata,
  input  logic [15:0] mem_err_evt,
  input  logic        ev_odd,
  input  logic        ev_nxm,
  input  logic        ev_tmo,
  input  logic        ev_yel,
  input  logic        ev_red,
  output logic        rsp_valid,
  output logic        rsp_nxm,
  output logic [15:0] rsp_rdata
);
  localparam logic [DW-1:0] SIZE_VAL = DW'((MEM_BYTES >> 6) - 1);

  logic [NSLOT-1:0] hit;
  logic             nxm_c;
  logic [NSLOT-1:0] wr_hit;
  logic [DW-1:0]    lane_m;
  logic [DW-1:0]    mem_q, ccr_q, maint_q, hm_q, ubrk_q, sysid_q;
  logic [DW-1:0]    cpuerr_q, cpuerr_view, ce_evt;
  logic [DW-1:0]    rdata_c;
  logic             ce_rd;

  sysreg_decode u_dec (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .hit       (hit),
    .nxm       (nxm_c)
  );

  assign wr_hit = req_write ? hit : '0;
  assign lane_m = lane_mask(req_byte, req_addr[0]);

  sysreg_cell #(.W(DW), .WMASK(MEM_WMASK), .W1C(1'b1)) u_mem (
    .clk(clk), .rst(rst), .wr_en(wr_hit[SLOT_MEMERR]), .lane_m(lane_m),
    .wdata(req_wdata), .set_evt(mem_err_evt), .q(mem_q)
  );

  sysreg_cell #(.W(DW), .WMASK(CCR_WMASK)) u_ccr (
    .clk(clk), .rst(rst), .wr_en(wr_hit[SLOT_CACHE]), .lane_m(lane_m),
    .wdata(req_wdata), .set_evt('0), .q(ccr_q)
  );

  sysreg_cell #(.W(DW), .WMASK(MAINT_WMASK)) u_maint (
    .clk(clk), .rst(rst), .wr_en(wr_hit[SLOT_MAINT]), .lane_m(lane_m),
    .wdata(req_wdata), .set_evt('0), .q(maint_q)
  );

  sysreg_cell #(.W(DW), .WMASK(HM_WMASK)) u_hm (
    .clk(clk), .rst(rst), .wr_en(wr_hit[SLOT_HITMISS]), .lane_m(lane_m),
    .wdata(req_wdata), .set_evt('0), .q(hm_q)
  );

  sysreg_cell #(.W(DW), .WMASK(UBRK_WMASK)) u_ubrk (
    .clk(clk), .rst(rst), .wr_en(wr_hit[SLOT_UBRK]), .lane_m(lane_m),
    .wdata(req_wdata), .set_evt('0), .q(ubrk_q)
  );

  sysreg_cell #(.W(DW), .RST_VAL(SYSID_RST), .WMASK('0)) u_sysid (
    .clk(clk), .rst(rst), .wr_en(wr_hit[SLOT_SYSID]), .lane_m(lane_m),
    .wdata(req_wdata), .set_evt('0), .q(sysid_q)
  );

  always_comb begin
    ce_evt         = '0;
    ce_evt[CE_ODD] = ev_odd;
    ce_evt[CE_NXM] = ev_nxm;
    ce_evt[CE_TMO] = ev_tmo;
    ce_evt[CE_YEL] = ev_yel;
    ce_evt[CE_RED] = ev_red;
  end

  assign ce_rd = hit[SLOT_CPUERR] && !req_write;

  sysreg_cpuerr u_ce (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (ce_rd),
    .wr_en   (wr_hit[SLOT_CPUERR]),
    .evt     (ce_evt),
    .q       (cpuerr_q),
    .rd_view (cpuerr_view)
  );

  always_comb begin
    rdata_c = '0;
    case (req_addr[4:1])
      SLOT_MEMERR:  rdata_c = mem_q & MEM_RMASK;
      SLOT_CACHE:   rdata_c = ccr_q & CCR_RMASK;
      SLOT_MAINT:   rdata_c = maint_q & MAINT_RMASK;
      SLOT_HITMISS: begin
        rdata_c = hm_q & HM_RMASK;
        rdata_c[HM_FORCE_BIT] = 1'b1;
      end
      SLOT_SIZE:    rdata_c = SIZE_VAL;
      SLOT_SYSID:   rdata_c = sysid_q;
      SLOT_CPUERR:  rdata_c = cpuerr_view & CE_RMASK;
      SLOT_UBRK:    rdata_c = ubrk_q & UBRK_RMASK;
      default:      rdata_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_nxm   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_nxm   <= nxm_c;
      rsp_rdata <= (req_valid && !req_write && !nxm_c) ? rdata_c : '0;
    end
  end
endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk #(
  parameter int unsigned MEM_BYTES = 262144,
  parameter logic [15:0] SYSID_RST = 16'h1234
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_write,
  input logic [4:0]  req_addr,
  input logic        ev_odd,
  input logic        rsp_valid,
  input logic        rsp_nxm,
  input logic [15:0] rsp_rdata,
  input logic [15:0] cpuerr_q
);
  localparam logic [15:0] SIZE_EXP = 16'((MEM_BYTES >> 6) - 1);

  logic [3:0] s;
  logic       empty_slot;
  assign s = req_addr[4:1];
  assign empty_slot = !(s == 4'd2 || s == 4'd3 || s == 4'd4 || s == 4'd5 ||
                        s == 4'd8 || s == 4'd10 || s == 4'd11 || s == 4'd13);

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R4
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R4
  AST_NXM_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && empty_slot) |=> (rsp_nxm && rsp_rdata == 16'h0)); // R2
  AST_HM_BIT3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && s == 4'd5) |=> rsp_rdata[3]); // R12
  AST_SIZE_FIXED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && s == 4'd8) |=> (rsp_rdata == SIZE_EXP)); // R10
  AST_SYSID_FIXED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && s == 4'd10) |=> (rsp_rdata == SYSID_RST)); // R11
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
    ev_odd |=> cpuerr_q[6]); // R9
endmodule

bind sysreg_bank sysreg_bank_chk #(.MEM_BYTES(MEM_BYTES), .SYSID_RST(SYSID_RST)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .ev_odd    (ev_odd),
  .rsp_valid (rsp_valid),
  .rsp_nxm   (rsp_nxm),
  .rsp_rdata (rsp_rdata),
  .cpuerr_q  (cpuerr_q)
);

// File: tb/sim_sysreg_bank.sv
`timescale 1ns/1ps
module sim_sysreg_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0, mem_err_evt = '0;
  logic        ev_odd = 1'b0, ev_nxm = 1'b0, ev_tmo = 1'b0, ev_yel = 1'b0, ev_red = 1'b0;
  logic        rsp_valid, rsp_nxm;
  logic [15:0] rsp_rdata;

  always #4 clk = ~clk;

  sysreg_bank u0 (.*);

  int compared = 0, mismatched = 0, cyc = 0;
  bit done = 0;
  string cur_tag = "R13";

  // reference model state
  logic [15:0] m_mem, m_ccr, m_maint, m_hm, m_ubrk, m_ce;
  logic        exp_valid = 0, exp_nxm = 0;
  logic [15:0] exp_data = 0;
  string       exp_tag = "R13";

  always @(posedge clk) begin
    logic [15:0] lm, t;
    int s;
    bit impl;
    if (rst) begin
      m_mem = 0; m_ccr = 0; m_maint = 0; m_hm = 0; m_ubrk = 0; m_ce = 0;
      exp_valid = 0; exp_nxm = 0; exp_data = 0;
    end else begin
      exp_valid = req_valid; exp_nxm = 0; exp_data = 0; exp_tag = cur_tag;
      if (req_valid) begin
        s = int'(req_addr[4:1]);
        lm = !req_byte ? 16'hFFFF : (req_addr[0] ? 16'hFF00 : 16'h00FF);
        impl = (s == 2 || s == 3 || s == 4 || s == 5 || s == 8 || s == 10 || s == 11 || s == 13);
        exp_nxm = !impl;
        if (!req_write) begin
          case (s)
            2:  exp_data = m_mem;
            3:  exp_data = m_ccr & 16'h3FFF;
            4:  exp_data = m_maint;
            5:  exp_data = m_hm | 16'h0008;
            8:  exp_data = 16'd4095;
            10: exp_data = 16'h1234;
            11: begin
              t = m_ce;
              if (t[3]) begin t[3] = 0; t[2] = 1; end
              if (t[6:4] != 0) t[0] = 1;
              m_ce = t;
              exp_data = t & 16'h007D;
            end
            13: exp_data = m_ubrk & 16'h00FF;
            default: exp_data = 0;
          endcase
        end else begin
          case (s)
            2:  m_mem = m_mem & ~(req_wdata & lm);
            3:  m_ccr = (m_ccr & ~(lm & 16'h3FFF)) | (req_wdata & lm & 16'h3FFF);
            4:  m_maint = (m_maint & ~(lm & 16'h00FF)) | (req_wdata & lm & 16'h00FF);
            5:  m_hm = (m_hm & ~(lm & 16'h00FF)) | (req_wdata & lm & 16'h00FF);
            11: m_ce = 0;
            13: m_ubrk = (m_ubrk & ~(lm & 16'h00FF)) | (req_wdata & lm & 16'h00FF);
            default: ;
          endcase
        end
      end
      m_mem = m_mem | mem_err_evt;
      m_ce = m_ce | {9'b0, ev_odd, ev_nxm, ev_tmo, ev_yel, ev_red, 2'b0};
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (rsp_valid !== exp_valid) begin
        mismatched++;
        $display("FAIL R4 rsp_valid actual=%b expected=%b", rsp_valid, exp_valid);
      end
      if (exp_valid) begin
        compared++;
        if (rsp_nxm !== exp_nxm || rsp_rdata !== exp_data) begin
          mismatched++;
          $display("FAIL %s nxm/rdata actual=%b/%h expected=%b/%h",
                   exp_tag, rsp_nxm, rsp_rdata, exp_nxm, exp_data);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // cev bits: [4]=odd [3]=nxm [2]=tmo [1]=yel [0]=red
  task automatic op(input bit v, input bit w, input bit b, input logic [4:0] a,
                    input logic [15:0] d, input logic [15:0] mev, input logic [4:0] cev);
    @(negedge clk);
    req_valid = v; req_write = w; req_byte = b; req_addr = a; req_wdata = d;
    mem_err_evt = mev;
    {ev_odd, ev_nxm, ev_tmo, ev_yel, ev_red} = cev;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_byte = 0; mem_err_evt = 0;
    {ev_odd, ev_nxm, ev_tmo, ev_yel, ev_red} = 5'b0;
  endtask

  task automatic rd(input logic [4:0] a);
    op(1, 0, 0, a, 16'h0, 16'h0, 5'b0);
  endtask
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    op(1, 1, 0, a, d, 16'h0, 5'b0);
  endtask
  task automatic wrb(input logic [4:0] a, input logic [15:0] d);
    op(1, 1, 1, a, d, 16'h0, 5'b0);
  endtask

  task automatic read_all();
    for (int i = 0; i < 16; i++) rd(5'(i * 2));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_tag = "R13"; read_all();
    cur_tag = "R1";  rd(5'h15); rd(5'h17); rd(5'h11);
    cur_tag = "R11"; wr(5'h14, 16'hFFFF); rd(5'h14);
    cur_tag = "R5";  wr(5'h06, 16'hFFFF); rd(5'h06); wr(5'h08, 16'hFFFF); rd(5'h08);
    wr(5'h1A, 16'hFFFF); rd(5'h1A);
    cur_tag = "R3";  wr(5'h06, 16'h1111); wrb(5'h07, 16'hAB00); rd(5'h06);
    wrb(5'h06, 16'h00CD); rd(5'h06); wrb(5'h1B, 16'h5500); rd(5'h1A);
    cur_tag = "R12"; wr(5'h0A, 16'h0000); rd(5'h0A); wr(5'h0A, 16'h00F0); rd(5'h0A);
    cur_tag = "R10"; rd(5'h10); wr(5'h10, 16'h0000); rd(5'h10);
    cur_tag = "R6";  op(1, 0, 0, 5'h00, 0, 16'hFFFF, 0); rd(5'h04);
    wr(5'h04, 16'h00F0); rd(5'h04); wrb(5'h05, 16'hFF00); rd(5'h04);
    op(1, 1, 0, 5'h04, 16'h0001, 16'h0001, 0); rd(5'h04);
    cur_tag = "R7";  op(0, 0, 0, 0, 0, 0, 5'b00010); rd(5'h16); rd(5'h16);
    cur_tag = "R8";  op(0, 0, 0, 0, 0, 0, 5'b00100); rd(5'h16);
    cur_tag = "R9";  wr(5'h16, 16'hFFFF); rd(5'h16);
    cur_tag = "R8";  op(0, 0, 0, 0, 0, 0, 5'b10000); rd(5'h16);
    cur_tag = "R9";  op(1, 1, 1, 5'h16, 16'h00FF, 0, 5'b01000); rd(5'h16);
    op(1, 0, 0, 5'h16, 0, 0, 5'b00001); rd(5'h16);
    cur_tag = "R2";  rd(5'h00); rd(5'h02); rd(5'h1E); wr(5'h0C, 16'hFFFF); rd(5'h0C);
    wr(5'h1C, 16'hFFFF); rd(5'h1C);
    cur_tag = "R4";  op(1, 0, 0, 5'h14, 0, 0, 0); op(1, 0, 0, 5'h10, 0, 0, 0);
    cur_tag = "R13"; wr(5'h06, 16'h0F0F); op(0, 0, 0, 0, 0, 16'h00AA, 5'b11111);
    @(negedge clk); rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    read_all();
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule